// File: doc/BRIEF.md
# Forward Channel Command/Data Merger

This block takes bytes from two host-side queues, one for command bytes and one for data bytes, and sends them one at a time over a single byte-wide forward channel. Each byte leaves with a tag bit: the tag is low for a command byte and high for a normal data byte. A command byte is passed through unchanged. Its top bit tells the receiver how to read the low seven bits: a clear bit 7 marks a run-length count and a set bit 7 marks a channel address.

To send a compressed run, the host writes the count into the command queue and the byte to be repeated into the data queue. Whenever a command is waiting, the merger sends it ahead of the next data byte. This keeps a count directly in front of the byte it governs. The channel side uses a valid/ready handshake that carries the byte and its tag. Each queue reports full, empty and a sticky overflow flag.

Top module: `fwd_cmd_merger`

## Requirements
- R1: `outTag` is 0 when the presented byte came from the command queue and 1 when it came from the data queue.
- R2: Command bytes leave unchanged. Bit 7 = 0 marks a run-length count in bits 6:0 and bit 7 = 1 marks a channel address in bits 6:0, and all values 0x00 to 0xFF pass intact.
- R3: If the command queue holds an entry when the output slot is loaded, a command is chosen over data. Each queue keeps first-in first-out order.
- R4: Each queue holds up to 16 bytes. `*Full` is high at 16 entries and `*Empty` is high at 0 entries.
- R5: A write to a full queue is dropped and sets that queue's overflow flag. The flag stays set until reset.
- R6: While `outValid` is high and `outReady` is low, `outValid`, `outByte` and `outTag` hold their values.
- R7: The output slot loads on any clock where it is empty or being accepted. A byte written into idle queues is presented on the clock after the write. With `outReady` held high, one byte moves per clock.
- R8: A synchronous reset empties both queues, clears both overflow flags and drops `outValid`.
- R9: Every accepted write leaves the channel exactly once. No byte is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmdWrEn | input | 1 | Write strobe for the command queue |
| cmdWrData | input | 8 | Command byte to enqueue |
| datWrEn | input | 1 | Write strobe for the data queue |
| datWrData | input | 8 | Data byte to enqueue |
| outReady | input | 1 | Channel accepts the presented byte |
| outValid | output | 1 | A byte is presented |
| outByte | output | 8 | Presented byte |
| outTag | output | 1 | 0 = command, 1 = data |
| cmdFull | output | 1 | Command queue holds 16 entries |
| cmdEmpty | output | 1 | Command queue holds no entries |
| cmdOverflow | output | 1 | Sticky: a command write was dropped |
| datFull | output | 1 | Data queue holds 16 entries |
| datEmpty | output | 1 | Data queue holds no entries |
| datOverflow | output | 1 | Sticky: a data write was dropped |

## Verification
The bench interleaves run-length counts and address commands with data while both queues are loaded. A design that let data win would separate a count from its byte. The bench stalls the channel with each queue at 16 entries and keeps writing. A design that accepted the extra byte, failed to latch overflow or let the presented byte drift would show a mismatch against the model. Under random back-pressure it checks that the presented byte never changes while stalled and that the accepted and delivered counts match. It also resets in the middle of traffic, so a design that left stale entries would later emit bytes nobody wrote.

// File: rtl/fct_pkg.sv
package fct_pkg;
  typedef struct packed {
    logic loadOut;  // load the output slot this clock
    logic selCmd;   // source is the command queue
    logic popCmd;
    logic popDat;
  } fct_strobe_t;
endpackage

// File: rtl/fct_fifo.sv
module fct_fifo #(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wrEn,
  input  logic [WIDTH-1:0] wrData,
  input  logic             rdEn,
  output logic [WIDTH-1:0] rdData,
  output logic             full,
  output logic             empty,
  output logic             overflow
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = AW + 1;
  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [AW-1:0] LAST_PTR = AW'(DEPTH - 1);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [AW-1:0]    wrPtr, rdPtr;
  logic [CW-1:0]    count;
  logic             pushOk, popOk;

  assign full   = (count == FULL_CNT);
  assign empty  = (count == '0);
  assign pushOk = wrEn && !full;
  assign popOk  = rdEn && !empty;
  assign rdData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wrPtr    <= '0;
      rdPtr    <= '0;
      count    <= '0;
      overflow <= 1'b0;
    end else begin
      if (pushOk) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (popOk)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
      if (wrEn && full) overflow <= 1'b1;
    end
  end

  // R4
  full_empty_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));
  // R5
  overflow_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    overflow |=> overflow);
  // R5
  full_drop_chk: assert property (@(posedge clk) disable iff (rst)
    full && wrEn && !rdEn |=> full && overflow);
endmodule

// File: rtl/fct_datapath.sv
module fct_datapath
  import fct_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  fct_strobe_t      strobes,
  input  logic             outReady,
  input  logic             cmdWrEn,
  input  logic [WIDTH-1:0] cmdWrData,
  input  logic             datWrEn,
  input  logic [WIDTH-1:0] datWrData,
  output logic             cmdFull,
  output logic             cmdEmpty,
  output logic             cmdOverflow,
  output logic             datFull,
  output logic             datEmpty,
  output logic             datOverflow,
  output logic             outValid,
  output logic [WIDTH-1:0] outByte,
  output logic             outTag
);
  localparam int unsigned NQ = 2;  // index 0: command, 1: data

  logic             qWrEn  [NQ];
  logic [WIDTH-1:0] qWrData[NQ];
  logic             qRdEn  [NQ];
  logic [WIDTH-1:0] qHead  [NQ];
  logic             qFull  [NQ];
  logic             qEmpty [NQ];
  logic             qOvf   [NQ];

  assign qWrEn[0]   = cmdWrEn;
  assign qWrData[0] = cmdWrData;
  assign qRdEn[0]   = strobes.popCmd;
  assign qWrEn[1]   = datWrEn;
  assign qWrData[1] = datWrData;
  assign qRdEn[1]   = strobes.popDat;

  for (genvar q = 0; q < NQ; q++) begin : g_queue
    fct_fifo #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wrEn(qWrEn[q]), .wrData(qWrData[q]),
      .rdEn(qRdEn[q]), .rdData(qHead[q]),
      .full(qFull[q]), .empty(qEmpty[q]), .overflow(qOvf[q])
    );
  end

  assign cmdFull     = qFull[0];
  assign cmdEmpty    = qEmpty[0];
  assign cmdOverflow = qOvf[0];
  assign datFull     = qFull[1];
  assign datEmpty    = qEmpty[1];
  assign datOverflow = qOvf[1];

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outByte  <= '0;
      outTag   <= 1'b0;
    end else if (strobes.loadOut) begin
      outValid <= 1'b1;
      outByte  <= strobes.selCmd ? qHead[0] : qHead[1];
      outTag   <= !strobes.selCmd;
    end else if (outReady) begin
      outValid <= 1'b0;
    end
  end

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (rst)
    outValid && !outReady |=> outValid && $stable(outByte) && $stable(outTag));
  // R1
  cmd_tag_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.loadOut && strobes.selCmd |=> !outTag);
  // R8
  reset_idle_chk: assert property (@(posedge clk)
    rst |=> !outValid);
endmodule

// File: rtl/fct_control.sv
module fct_control
  import fct_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cmdEmpty,
  input  logic        datEmpty,
  input  logic        outValid,
  input  logic        outReady,
  output fct_strobe_t strobes
);
  logic slotFree, haveCmd, haveDat;

  assign slotFree = !outValid || outReady;
  assign haveCmd  = !cmdEmpty;
  assign haveDat  = !datEmpty;

  always_comb begin
    strobes         = '0;
    strobes.loadOut = slotFree && (haveCmd || haveDat);
    strobes.selCmd  = haveCmd;
    strobes.popCmd  = strobes.loadOut && haveCmd;
    strobes.popDat  = strobes.loadOut && !haveCmd;
  end

  // R3
  cmd_first_chk: assert property (@(posedge clk) disable iff (rst)
    strobes.popDat |-> cmdEmpty);
  // R7
  slot_fill_chk: assert property (@(posedge clk) disable iff (rst)
    !outValid && !(cmdEmpty && datEmpty) |=> outValid);
endmodule

// File: rtl/fwd_cmd_merger.sv
module fwd_cmd_merger
  import fct_pkg::*;
#(
  parameter int unsigned WIDTH = 8,
  parameter int unsigned DEPTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cmdWrEn,
  input  logic [WIDTH-1:0] cmdWrData,
  input  logic             datWrEn,
  input  logic [WIDTH-1:0] datWrData,
  input  logic             outReady,
  output logic             outValid,
  output logic [WIDTH-1:0] outByte,
  output logic             outTag,
  output logic             cmdFull,
  output logic             cmdEmpty,
  output logic             cmdOverflow,
  output logic             datFull,
  output logic             datEmpty,
  output logic             datOverflow
);
  fct_strobe_t strobes;

  fct_control u_control (
    .clk(clk), .rst(rst),
    .cmdEmpty(cmdEmpty), .datEmpty(datEmpty),
    .outValid(outValid), .outReady(outReady),
    .strobes(strobes)
  );

  fct_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_datapath (
    .clk(clk), .rst(rst), .strobes(strobes), .outReady(outReady),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .datWrEn(datWrEn), .datWrData(datWrData),
    .cmdFull(cmdFull), .cmdEmpty(cmdEmpty), .cmdOverflow(cmdOverflow),
    .datFull(datFull), .datEmpty(datEmpty), .datOverflow(datOverflow),
    .outValid(outValid), .outByte(outByte), .outTag(outTag)
  );
endmodule

// File: tb/fwd_cmd_merger_bench.sv
`timescale 1ns/1ps
module fwd_cmd_merger_bench;
  localparam int DEPTH = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmdWrEn = 1'b0, datWrEn = 1'b0, outReady = 1'b0;
  logic [7:0] cmdWrData = '0, datWrData = '0;
  logic outValid, outTag, cmdFull, cmdEmpty, cmdOverflow, datFull, datEmpty, datOverflow;
  logic [7:0] outByte;

  always #2 clk = ~clk;  // 250 MHz

  fwd_cmd_merger u_fwd_cmd_merger (
    .clk(clk), .rst(rst),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData),
    .datWrEn(datWrEn), .datWrData(datWrData),
    .outReady(outReady), .outValid(outValid), .outByte(outByte), .outTag(outTag),
    .cmdFull(cmdFull), .cmdEmpty(cmdEmpty), .cmdOverflow(cmdOverflow),
    .datFull(datFull), .datEmpty(datEmpty), .datOverflow(datOverflow)
  );

  int total = 0, bad = 0, cyc = 0;

  // reference model
  logic [7:0] cmdQ[$];
  logic [7:0] datQ[$];
  logic       mValid = 0, mTag = 0, mCOvf = 0, mDOvf = 0;
  logic [7:0] mByte = '0;
  logic       holdPrev = 0, holdTag = 0;
  logic [7:0] holdByte = '0;
  int         accepted = 0, fired = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    int  preC, preD;
    logic slot;
    cyc++;
    if (rst) begin
      cmdQ.delete(); datQ.delete();
      mValid = 0; mTag = 0; mByte = '0; mCOvf = 0; mDOvf = 0;
      holdPrev = 0; accepted = 0; fired = 0;
    end else begin
      holdPrev = mValid && !outReady;
      holdByte = mByte;
      holdTag  = mTag;
      if (outValid && outReady) fired++;
      slot = !mValid || outReady;
      preC = cmdQ.size();
      preD = datQ.size();
      if (slot && preC > 0) begin
        mByte = cmdQ.pop_front(); mTag = 0; mValid = 1;
      end else if (slot && preD > 0) begin
        mByte = datQ.pop_front(); mTag = 1; mValid = 1;
      end else if (outReady) mValid = 0;
      if (cmdWrEn) begin
        if (preC < DEPTH) begin cmdQ.push_back(cmdWrData); accepted++; end
        else mCOvf = 1;
      end
      if (datWrEn) begin
        if (preD < DEPTH) begin datQ.push_back(datWrData); accepted++; end
        else mDOvf = 1;
      end
    end
  end

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    check("R7", "outValid", int'(outValid), int'(mValid));
    if (mValid) begin
      check("R3", "outByte", int'(outByte), int'(mByte));
      check("R1", "outTag", int'(outTag), int'(mTag));
    end
    check("R4", "cmdFull",  int'(cmdFull),  int'(cmdQ.size() == DEPTH));
    check("R4", "cmdEmpty", int'(cmdEmpty), int'(cmdQ.size() == 0));
    check("R4", "datFull",  int'(datFull),  int'(datQ.size() == DEPTH));
    check("R4", "datEmpty", int'(datEmpty), int'(datQ.size() == 0));
    check("R5", "cmdOverflow", int'(cmdOverflow), int'(mCOvf));
    check("R5", "datOverflow", int'(datOverflow), int'(mDOvf));
    if (holdPrev) begin
      check("R6", "held valid", int'(outValid), 1);
      check("R6", "held byte", int'(outByte), int'(holdByte));
      check("R6", "held tag", int'(outTag), int'(holdTag));
    end
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R9 watchdog actual=%0d expected<100000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic step(input logic cw, input logic [7:0] cd,
                      input logic dw, input logic [7:0] dd, input logic rdy);
    @(negedge clk);
    cmdWrEn = cw; cmdWrData = cd; datWrEn = dw; datWrData = dd; outReady = rdy;
  endtask

  task automatic idle(input int n, input logic rdy);
    for (int i = 0; i < n; i++) step(0, 8'h00, 0, 8'h00, rdy);
  endtask

  initial begin
    // R8: reset state
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    check("R8", "reset outValid", int'(outValid), 0);
    check("R8", "reset cmdEmpty", int'(cmdEmpty), 1);
    check("R8", "reset datEmpty", int'(datEmpty), 1);

    // R2: a command byte with bit 7 set reaches the channel unchanged, one clock after the write
    step(1, 8'hFF, 0, 8'h00, 1);
    step(0, 8'h00, 0, 8'h00, 1);
    @(negedge clk);
    check("R2", "address byte", int'(outByte), 8'hFF);
    check("R1", "address tag", int'(outTag), 0);
    idle(3, 1);

    // R2: counts and addresses at their edge values, each paired with data
    foreach (cmdQ[i]) ;
    begin
      logic [7:0] edgeVals[4] = '{8'h00, 8'h7F, 8'h80, 8'hFF};
      for (int i = 0; i < 4; i++) step(1, edgeVals[i], 1, 8'hA0 + 8'(i), 1);
    end
    idle(10, 1);

    // R3: load both queues under stall, then drain
    for (int i = 0; i < 6; i++) step(1, 8'(i + 1), 1, 8'h50 + 8'(i), 0);
    idle(3, 0);
    idle(20, 1);

    // R4 R5: data queue fills and overflows while stalled
    for (int i = 0; i < 20; i++) step(0, 8'h00, 1, 8'(8'hC0 + i), 0);
    idle(2, 0);
    idle(24, 1);
    // R5: command queue overflow
    for (int i = 0; i < 20; i++) step(1, 8'(8'h10 + i), 0, 8'h00, 0);
    idle(24, 1);

    // random traffic with back-pressure
    for (int i = 0; i < 3000; i++)
      step(($urandom % 3) == 0, 8'($urandom), ($urandom % 2) == 0, 8'($urandom),
           ($urandom % 4) != 0);
    idle(60, 1);
    // R9: every accepted byte delivered once
    check("R9", "delivered count", fired, accepted);

    // R8: reset in mid-traffic, then verify clean restart
    for (int i = 0; i < 10; i++) step(1, 8'(i), 1, 8'(8'h90 + i), 0);
    @(negedge clk); rst = 1; cmdWrEn = 0; datWrEn = 0;
    @(negedge clk); rst = 0;
    @(negedge clk);
    check("R8", "mid reset outValid", int'(outValid), 0);
    check("R8", "mid reset cmdEmpty", int'(cmdEmpty), 1);
    check("R8", "mid reset datEmpty", int'(datEmpty), 1);
    check("R8", "mid reset overflow", int'(cmdOverflow | datOverflow), 0);
    for (int i = 0; i < 40; i++) step(1, 8'(8'h20 + i), 1, 8'(8'h60 + i), 1);
    idle(100, 1);
    check("R9", "delivered after reset", fired, accepted);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule